// File: doc/BRIEF.md
# Direct-Mapped Data Cache Store Pipeline

This block is the write path of a small direct-mapped data cache. A store is split across two cycles so that the processor never has to stall for it. In the first cycle, the store's address is checked against the tag array to find out whether it hits. The store then waits in a delayed-write register until the next store arrives. In that later cycle, the waiting store writes the data array while the tag array checks the newer store.

Since the data array can lag one store behind, every load compares its word address with the held store. Where they match, the load merges the held bytes over the array word, so a load always returns the latest stored value.

A held store is written into the array in three cases: the next store arrives, an explicit drain request is raised, or a cycle passes with no request. A single-line refill port installs a new line together with its tag. If a store to the same index is still held at that moment, it is handled as follows:
- If the refilled tag matches the held store's tag, the store is merged over the new line.
- If the tags differ, the held store is dropped.

Misses are not allocated. Filling the cache is the job of the refill port alone.

Top module: `dcache_store_pipe`

## Requirements
- R1: After reset, no line is valid, so every load and every store misses, and `rsp_valid` stays low until the first request.
- R2: Each cycle with `req_valid` high produces exactly one response (`rsp_valid` high) on the following cycle. A cycle without a request produces `rsp_valid` low on the following cycle. This includes refill cycles.
- R3: A request hits exactly when the line at its index is valid and holds its tag. Word address bit [0] selects the word within a line, bits [2:1] are the index and bits [5:3] are the tag (default configuration). A load hit returns the word. A load miss, and every store response, returns zero data. A store response carries the hit flag.
- R4: A load issued in the cycle right after a store hit to the same word returns the new value. There is no waiting for the array write.
- R5: `req_be` bit b enables data bits [8b+7:8b]. Only the enabled bytes change. A load to the other word of the same line returns that word untouched.
- R6: A store that misses changes nothing. The word resident at the same index and offset keeps its value.
- R7: Two back-to-back stores to the same word take effect in order. Bytes of the later store override the earlier one, and the earlier store's other bytes remain.
- R8: A held store stays held across load cycles. It is written into the array when a cycle has no request, or when `flush` is high (with or without a load in that cycle). Once written, a later refill of that line replaces it.
- R9: A refill, applied only in cycles without a request, writes all words of the line and its tag, and marks the line valid. Word k of the line is taken from bits [32k+31:32k] of `refill_line`. A store still held for that index is merged over the refill if its tag equals the refill tag, and is discarded otherwise.
- R10: A refill at a different index leaves the effect of a held store intact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | A request is presented this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Word address: tag, index and word offset |
| req_wdata | input | DATA_W | Store data |
| req_be | input | DATA_W/8 | Store byte enables |
| flush | input | 1 | Write the held store into the array this cycle |
| refill_valid | input | 1 | Install a line this cycle |
| refill_addr | input | ADDR_W-OFF_W | Line address: tag above index |
| refill_line | input | DATA_W<<OFF_W | Line contents, word 0 in the low bits |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_hit | output | 1 | That request hit |
| rsp_data | output | DATA_W | Load data, zero on miss or store |

## Verification
The assertions take for granted that a refill never shares a cycle with a request. This is the case in which the design treats the refill cycle as idle for the held store. The stimulus drives the refill port only from its own task, which lowers `req_valid` in the same cycle.

The sweeps also use `flush` only together with a load or on an idle cycle. This keeps the held-store state that the bench's model tracks unambiguous. The model computes every expected word from the stored bytes, and it follows the commit, merge and drop rules above.

// File: rtl/st_pkg.sv
package st_pkg;

  typedef enum logic [1:0] {
    PEND_HOLD    = 2'd0,
    PEND_CAPTURE = 2'd1,
    PEND_DRAIN   = 2'd2
  } pend_op_e;

endpackage

// File: rtl/st_tag_array.sv
module st_tag_array #(
  parameter int TAG_W = 3,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0] vld_q, vld_d;
  logic [TAG_W-1:0] tag_q [LINES];

  always_comb begin
    vld_d = vld_q;
    if (fill_en) vld_d[fill_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[fill_idx] <= fill_tag;
  end

  assign lk_hit = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);

  AST_FILL_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> vld_q[$past(fill_idx)]); // R9

endmodule

// File: rtl/st_data_array.sv
module st_data_array #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 2,
  parameter int OFF_W  = 1
) (
  input  logic                      clk,
  input  logic [IDX_W+OFF_W-1:0]    rd_ent,
  output logic [DATA_W-1:0]         rd_word,
  input  logic                      wr_en,
  input  logic [IDX_W+OFF_W-1:0]    wr_ent,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic [DATA_W/8-1:0]       wr_be,
  input  logic                      fill_en,
  input  logic [IDX_W-1:0]          fill_idx,
  input  logic [(DATA_W<<OFF_W)-1:0] fill_line
);
  localparam int E_W  = IDX_W + OFF_W;
  localparam int ENT  = 1 << E_W;
  localparam int WPL  = 1 << OFF_W;
  localparam int BE_W = DATA_W / 8;

  logic [DATA_W-1:0] mem_q [ENT];
  logic [DATA_W-1:0] mem_d [ENT];
  logic [ENT-1:0]    upd;

  // Refill first, then the committed store bytes on top of it.
  always_comb begin
    for (int e = 0; e < ENT; e++) begin
      mem_d[e] = mem_q[e];
      upd[e]   = 1'b0;
      if (fill_en && (fill_idx == IDX_W'(e >> OFF_W))) begin
        mem_d[e] = fill_line[(e % WPL)*DATA_W +: DATA_W];
        upd[e]   = 1'b1;
      end
      if (wr_en && (wr_ent == E_W'(e))) begin
        for (int b = 0; b < BE_W; b++) begin
          if (wr_be[b]) mem_d[e][8*b +: 8] = wr_data[8*b +: 8];
        end
        upd[e] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int e = 0; e < ENT; e++) begin
      if (upd[e]) mem_q[e] <= mem_d[e];
    end
  end

  assign rd_word = mem_q[rd_ent];

endmodule

// File: rtl/st_delay_wr.sv
module st_delay_wr
  import st_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cap_en,
  input  logic                cap_hit,
  input  logic [ADDR_W-1:0]   cap_addr,
  input  logic [DATA_W-1:0]   cap_data,
  input  logic [DATA_W/8-1:0] cap_be,
  input  logic                drain,
  output logic                pend_vld,
  output logic [ADDR_W-1:0]   pend_addr,
  output logic [DATA_W-1:0]   pend_data,
  output logic [DATA_W/8-1:0] pend_be,
  input  logic [ADDR_W-1:0]   fwd_addr,
  input  logic [DATA_W-1:0]   fwd_base,
  output logic [DATA_W-1:0]   fwd_word
);
  localparam int BE_W = DATA_W / 8;

  pend_op_e            op;
  logic                vld_q, vld_d;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   data_q;
  logic [BE_W-1:0]     be_q;
  logic                fwd_match;

  always_comb begin
    if (cap_en)     op = PEND_CAPTURE;
    else if (drain) op = PEND_DRAIN;
    else            op = PEND_HOLD;
    case (op)
      PEND_CAPTURE: vld_d = cap_hit;
      PEND_DRAIN:   vld_d = 1'b0;
      default:      vld_d = vld_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      addr_q <= cap_addr;
      data_q <= cap_data;
      be_q   <= cap_be;
    end
  end

  assign pend_vld  = vld_q;
  assign pend_addr = addr_q;
  assign pend_data = data_q;
  assign pend_be   = be_q;

  assign fwd_match = vld_q && (addr_q == fwd_addr);

  for (genvar b = 0; b < BE_W; b++) begin : g_fwd_byte
    assign fwd_word[8*b +: 8] = (fwd_match && be_q[b]) ? data_q[8*b +: 8]
                                                       : fwd_base[8*b +: 8];
  end

  AST_MISS_NOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en && !cap_hit |=> !pend_vld); // R6
  AST_HIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en && cap_hit |=> pend_vld); // R4
  AST_DRAIN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    drain && !cap_en |=> !pend_vld); // R8

endmodule

// File: rtl/dcache_store_pipe.sv
module dcache_store_pipe #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 2,
  parameter int OFF_W  = 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic                       req_store,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [DATA_W-1:0]          req_wdata,
  input  logic [DATA_W/8-1:0]        req_be,
  input  logic                       flush,
  input  logic                       refill_valid,
  input  logic [ADDR_W-OFF_W-1:0]    refill_addr,
  input  logic [(DATA_W<<OFF_W)-1:0] refill_line,
  output logic                       rsp_valid,
  output logic                       rsp_hit,
  output logic [DATA_W-1:0]          rsp_data
);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
  localparam int E_W   = IDX_W + OFF_W;
  localparam int BE_W  = DATA_W / 8;

  logic [TAG_W-1:0]  req_tag, pend_tag, fill_tag;
  logic [IDX_W-1:0]  req_idx, pend_idx, fill_idx;
  logic              is_store, is_load, lk_hit;
  logic              pend_vld, drain, cancel, commit_en;
  logic [ADDR_W-1:0] pend_addr;
  logic [DATA_W-1:0] pend_data, arr_word, fwd_word;
  logic [BE_W-1:0]   pend_be;

  logic              rsp_valid_q, rsp_valid_d, rsp_hit_q, rsp_hit_d;
  logic [DATA_W-1:0] rsp_data_q, rsp_data_d;

  assign req_tag  = req_addr[ADDR_W-1 -: TAG_W];
  assign req_idx  = req_addr[OFF_W +: IDX_W];
  assign pend_tag = pend_addr[ADDR_W-1 -: TAG_W];
  assign pend_idx = pend_addr[OFF_W +: IDX_W];
  assign fill_tag = refill_addr[ADDR_W-OFF_W-1 -: TAG_W];
  assign fill_idx = refill_addr[IDX_W-1:0];

  assign is_store = req_valid && req_store;
  assign is_load  = req_valid && !req_store;

  // The held store leaves on a new store, a drain request or an idle cycle;
  // a refill replacing its line with another tag discards it instead.
  assign drain     = pend_vld && (!req_valid || flush || is_store);
  assign cancel    = refill_valid && (pend_idx == fill_idx) && (pend_tag != fill_tag);
  assign commit_en = drain && !cancel;

  st_tag_array #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_idx   (req_idx),
    .lk_tag   (req_tag),
    .lk_hit   (lk_hit),
    .fill_en  (refill_valid),
    .fill_idx (fill_idx),
    .fill_tag (fill_tag)
  );

  st_delay_wr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pend (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_en    (is_store),
    .cap_hit   (lk_hit),
    .cap_addr  (req_addr),
    .cap_data  (req_wdata),
    .cap_be    (req_be),
    .drain     (drain),
    .pend_vld  (pend_vld),
    .pend_addr (pend_addr),
    .pend_data (pend_data),
    .pend_be   (pend_be),
    .fwd_addr  (req_addr),
    .fwd_base  (arr_word),
    .fwd_word  (fwd_word)
  );

  st_data_array #(.DATA_W(DATA_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_data (
    .clk       (clk),
    .rd_ent    (req_addr[E_W-1:0]),
    .rd_word   (arr_word),
    .wr_en     (commit_en),
    .wr_ent    (pend_addr[E_W-1:0]),
    .wr_data   (pend_data),
    .wr_be     (pend_be),
    .fill_en   (refill_valid),
    .fill_idx  (fill_idx),
    .fill_line (refill_line)
  );

  always_comb begin
    rsp_valid_d = req_valid;
    rsp_hit_d   = req_valid && lk_hit;
    rsp_data_d  = (is_load && lk_hit) ? fwd_word : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      rsp_hit_q   <= rsp_hit_d;
      rsp_data_q  <= rsp_data_d;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_hit   = rsp_hit_q;
  assign rsp_data  = rsp_data_q;

  AST_RSP_TRACKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R2
  AST_NO_RSP_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R2
  AST_MISS_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_hit |-> rsp_data == '0); // R3
  AST_IDLE_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
    pend_vld && !req_valid |=> !pend_vld); // R8
  AST_REFILL_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    refill_valid |-> !req_valid); // R9

endmodule

// File: tb/dcache_store_pipe_bench.sv
`timescale 1ns/1ps
module dcache_store_pipe_bench;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_store, flush, refill_valid;
  logic [5:0]  req_addr;
  logic [31:0] req_wdata;
  logic [3:0]  req_be;
  logic [4:0]  refill_addr;
  logic [63:0] refill_line;
  logic        rsp_valid, rsp_hit;
  logic [31:0] rsp_data;

  int vectors = 0;
  int miscompares = 0;

  // expected-state model
  logic [31:0] m_arr [8];
  logic [2:0]  m_tag [4];
  bit          m_vld [4];
  bit          m_pv;
  logic [5:0]  m_pa;
  logic [31:0] m_pd;
  logic [3:0]  m_pb;

  always #2.5 clk = ~clk;

  dcache_store_pipe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(2), .OFF_W(1))
  u_dcache_store_pipe (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be), .flush(flush),
    .refill_valid(refill_valid), .refill_addr(refill_addr), .refill_line(refill_line),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data)
  );

  function automatic logic [31:0] merge(input logic [31:0] base, input logic [31:0] d,
                                        input logic [3:0] be);
    logic [31:0] r = base;
    for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = d[8*b +: 8];
    return r;
  endfunction

  function automatic logic [31:0] wpat(input logic [2:0] t, input logic [1:0] i,
                                       input bit w, input logic [7:0] salt);
    return {salt, 5'd0, t, 6'd0, i, 7'd0, w} ^ 32'h0050_A500;
  endfunction

  task automatic chk(input string rq, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: got %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic model_commit();
    if (m_pv) m_arr[m_pa[2:0]] = merge(m_arr[m_pa[2:0]], m_pd, m_pb);
  endtask

  task automatic do_req(input bit st, input logic [5:0] a, input logic [31:0] d,
                        input logic [3:0] be, input bit fl, input string rq);
    bit hit;
    logic [31:0] exp;
    @(negedge clk);
    req_valid = 1'b1; req_store = st; req_addr = a; req_wdata = d; req_be = be;
    flush = fl; refill_valid = 1'b0;
    hit = m_vld[a[2:1]] && (m_tag[a[2:1]] == a[5:3]);
    exp = '0;
    if (!st && hit) begin
      exp = m_arr[a[2:0]];
      if (m_pv && m_pa == a) exp = merge(exp, m_pd, m_pb);
    end
    if (st || fl) begin model_commit(); m_pv = 0; end
    if (st) begin m_pv = hit; m_pa = a; m_pd = d; m_pb = be; end
    @(posedge clk); #1;
    chk(rq, "rsp_valid", {31'd0, rsp_valid}, 32'd1);
    chk(rq, "rsp_hit", {31'd0, rsp_hit}, {31'd0, hit});
    chk(rq, "rsp_data", rsp_data, exp);
  endtask

  task automatic do_idle(input string rq);
    @(negedge clk);
    req_valid = 1'b0; flush = 1'b0; refill_valid = 1'b0;
    model_commit(); m_pv = 0;
    @(posedge clk); #1;
    chk(rq, "rsp_valid idle", {31'd0, rsp_valid}, 32'd0);
  endtask

  task automatic do_refill(input logic [2:0] t, input logic [1:0] i,
                           input logic [7:0] salt, input string rq);
    @(negedge clk);
    req_valid = 1'b0; flush = 1'b0; refill_valid = 1'b1;
    refill_addr = {t, i};
    refill_line = {wpat(t, i, 1'b1, salt), wpat(t, i, 1'b0, salt)};
    m_arr[{i, 1'b0}] = wpat(t, i, 1'b0, salt);
    m_arr[{i, 1'b1}] = wpat(t, i, 1'b1, salt);
    if (m_pv && (m_pa[2:1] != i || m_pa[5:3] == t)) model_commit();
    m_pv = 0; m_tag[i] = t; m_vld[i] = 1;
    @(posedge clk); #1;
    chk(rq, "rsp_valid refill", {31'd0, rsp_valid}, 32'd0);
  endtask

  initial begin
    #(200000 * 5);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 0; req_store = 0; req_addr = '0; req_wdata = '0;
    req_be = '0; flush = 0; refill_valid = 0; refill_addr = '0; refill_line = '0;
    for (int k = 0; k < 4; k++) begin m_vld[k] = 0; m_tag[k] = '0; end
    for (int k = 0; k < 8; k++) m_arr[k] = '0;
    m_pv = 0; m_pa = '0; m_pd = '0; m_pb = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);

    // R1: nothing valid yet, loads and stores miss
    for (int a = 0; a < 64; a++) do_req(0, 6'(a), '0, 4'h0, 0, "R1");
    for (int a = 0; a < 8; a++) do_req(1, 6'(a), 32'hFFFF_FFFF, 4'hF, 0, "R1");
    do_idle("R2");

    // R9: install all lines with tag 0
    for (int i = 0; i < 4; i++) do_refill(3'd0, 2'(i), 8'h11, "R9");
    for (int a = 0; a < 8; a++) do_req(0, 6'(a), '0, 4'h0, 0, "R3");

    // R4/R5: every word, every byte-enable pattern, forwarding and other word
    for (int a = 0; a < 8; a++) begin
      for (int be = 0; be < 16; be++) begin
        do_req(1, 6'(a), 32'hC0DE_0000 | (a << 8) | be, 4'(be), 0, "R5");
        do_req(0, 6'(a), '0, 4'h0, 0, "R4");
        do_req(0, 6'(a ^ 1), '0, 4'h0, 0, "R5");
      end
    end
    do_idle("R2");

    // R7: back-to-back stores to one word
    for (int a = 0; a < 8; a++) begin
      do_req(1, 6'(a), 32'h1111_1111 * (a + 1), 4'b0011, 0, "R7");
      do_req(1, 6'(a), 32'h0A0B_0C0D + a, 4'b0110, 0, "R7");
      do_req(0, 6'(a), '0, 4'h0, 0, "R7");
      do_idle("R7");
      do_req(0, 6'(a), '0, 4'h0, 0, "R7");
    end

    // R6: store misses leave resident words alone
    for (int t = 1; t < 8; t++) begin
      for (int a = 0; a < 8; a++) begin
        do_req(1, {3'(t), 3'(a)}, 32'hBAD0_0000 | t, 4'hF, 0, "R6");
        do_req(0, {3'd0, 3'(a)}, '0, 4'h0, 0, "R6");
        do_req(0, {3'(t), 3'(a)}, '0, 4'h0, 0, "R6");
      end
    end

    // R8: held through loads, merged over a same-tag refill
    do_req(1, 6'd2, 32'hDEAD_BEEF, 4'hF, 0, "R8");
    do_req(0, 6'd2, '0, 4'h0, 0, "R4");
    do_refill(3'd0, 2'd1, 8'h07, "R8");
    do_req(0, 6'd2, '0, 4'h0, 0, "R8");
    do_req(0, 6'd3, '0, 4'h0, 0, "R8");
    // R8: flush with a load commits, later refill replaces it
    do_req(1, 6'd2, 32'h1234_5678, 4'b1010, 0, "R8");
    do_req(0, 6'd3, '0, 4'h0, 1, "R8");
    do_refill(3'd0, 2'd1, 8'h08, "R8");
    do_req(0, 6'd2, '0, 4'h0, 0, "R8");
    // R8: idle cycle commits
    do_req(1, 6'd2, 32'h5555_AAAA, 4'hF, 0, "R8");
    do_idle("R8");
    do_refill(3'd0, 2'd1, 8'h09, "R8");
    do_req(0, 6'd2, '0, 4'h0, 0, "R8");

    // R9: refill with a different tag discards the held store
    do_req(1, 6'd4, 32'hFACE_F00D, 4'hF, 0, "R9");
    do_req(0, 6'd4, '0, 4'h0, 0, "R9");
    do_refill(3'd5, 2'd2, 8'h0A, "R9");
    do_req(0, 6'd44, '0, 4'h0, 0, "R9");
    do_req(0, 6'd45, '0, 4'h0, 0, "R9");
    do_req(0, 6'd4, '0, 4'h0, 0, "R9");
    do_refill(3'd0, 2'd2, 8'h0B, "R9");
    do_req(0, 6'd4, '0, 4'h0, 0, "R9");

    // R10: refill elsewhere keeps the held store
    do_req(1, 6'd6, 32'h0BAD_CAFE, 4'b0101, 0, "R10");
    do_req(0, 6'd6, '0, 4'h0, 0, "R10");
    do_refill(3'd2, 2'd0, 8'h0C, "R10");
    do_req(0, 6'd6, '0, 4'h0, 0, "R10");
    do_req(0, 6'd16, '0, 4'h0, 0, "R10");

    // mixed sweep over tags 0..3
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r;
      logic [5:0]  a;
      r = $urandom;
      a = {1'b0, r[9:8], r[12:10]};
      case (r[2:0])
        3'd0, 3'd1, 3'd2: do_req(0, a, '0, 4'h0, 0, "R3");
        3'd3, 3'd4:       do_req(1, a, $urandom, r[16:13], 0, "R7");
        3'd5:             do_idle("R8");
        3'd6:             do_req(0, a, '0, 4'h0, 1, "R8");
        default:          do_refill({1'b0, r[18:17]}, r[20:19], 8'(n), "R9");
      endcase
    end
    do_idle("R2");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule